// File: doc/BRIEF.md
# Infrared Remote Frame Decoder

This block turns one sampled infrared receiver line into decoded remote-control frames. A frame opens with a long active leader burst and an idle space. Thirty-two pulse-distance coded bits follow, each one an active mark and then an idle gap whose length gives the bit value. A final stop mark closes the frame. The line is first synchronised and brought to an internal "active" level according to a polarity input. The length of every active and idle interval is then measured in microseconds by counting system clocks. A frame state machine classifies each interval against tolerance windows and assembles the fields.

Two field layouts are supported and chosen by a run-time input. In standard layout the frame carries an 8-bit address, its complement, an 8-bit command and its complement. In extended layout a 16-bit address that is not checked is followed by the command and its complement. A frame that passes every check raises a one-cycle valid strobe and updates the address and command outputs. A failed complement, a malformed interval or a stalled line inside a frame raises a one-cycle error strobe and sends the decoder back to waiting for a leader. A leader followed by a short space raises a one-cycle repeat strobe.

Top module: `ir_frame_decoder`

## Requirements
- R1: With `pol_hi`=0 the line is active when low; with `pol_hi`=1 it is active when high. The same frame decodes to the same address and command under either setting when the line is driven with the matching sense.
- R2: In standard layout (`ext_mode`=0) the bits arrive least-significant first in this order: address byte, complement of the address, command byte, complement of the command. A frame that passes both checks and ends with a valid stop mark pulses `frame_valid` for one cycle, sets `addr_o` to {8'h00, address} and sets `cmd_o` to the command.
- R3: In extended layout (`ext_mode`=1) the first 16 bits form the address, least-significant first, and are accepted whatever their value. `addr_o` takes all 16 bits, and the command and its complement follow as in R2.
- R4: In standard layout, if the address XOR its received complement is not 8'hFF, `frame_err` pulses and `err_raw` = {received complement, address} with the complement in bits 15:8. No `frame_valid` follows for that frame.
- R5: If the command XOR its received complement is not 8'hFF, `frame_err` pulses and `err_raw` = {received complement, command}. No `frame_valid` follows for that frame.
- R6: Each interval is accepted within ±25 % of its nominal length: leader mark 9000 us, leader space 4500 us, repeat space 2250 us, bit mark 562 us, zero gap 562 us, one gap 1687 us. Intervals near the window edges decode normally. Inside a frame, an interval that fits no allowed window pulses `frame_err` with `err_raw` = 0 and returns the decoder to idle.
- R7: Inside a frame, a line held at one level for longer than the timeout (12000 us) pulses `frame_err` with `err_raw` = 0, without waiting for the next edge.
- R8: A leader mark followed by a space in the repeat window pulses `repeat_seen` for one cycle and does not pulse `frame_valid` or `frame_err`.
- R9: `frame_valid`, `frame_err` and `repeat_seen` each last one cycle and never coincide. `addr_o` and `cmd_o` keep their values until the next valid frame.
- R10: After reset every output is zero.
- R11: While idle, pulses that are not a leader mark are ignored and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Raw receiver line |
| pol_hi | input | 1 | 1: line is active-high, 0: active-low |
| ext_mode | input | 1 | 1: extended 16-bit address layout |
| addr_o | output | 16 | Address of the last valid frame |
| cmd_o | output | 8 | Command of the last valid frame |
| frame_valid | output | 1 | One-cycle strobe for a complete, checked frame |
| frame_err | output | 1 | One-cycle strobe for an aborted frame |
| err_raw | output | 16 | Field and complement that failed a check, 0 for a timing error |
| repeat_seen | output | 1 | One-cycle strobe for a repeat code |

## Verification
A bit counter or field assembly that slips shows up as a wrong `addr_o` or `cmd_o`, or as a complement error, at the end of the frame in which the slip happens. A misplaced check shows up as a false `frame_err` at the 16th or 32nd bit edge. A state that fails to return to idle after an abort shows up on the following frame, as a missing `frame_valid` or a spurious error. The directed scenarios therefore read every strobe counter and captured value a few cycles after the stop mark or after the offending edge.

// File: rtl/ir_pkg.sv
package ir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LSPACE,
        ST_BMARK,
        ST_BSPACE,
        ST_STOP
    } ir_state_e;

    localparam int FRAME_BITS = 32;

    typedef struct packed {
        ir_state_e                state;
        logic [4:0]               cnt;
        logic [FRAME_BITS-1:0]    data;
        logic [15:0]              addr;
        logic [7:0]               cmd;
        logic [15:0]              err_raw;
        logic                     valid;
        logic                     err;
        logic                     rpt;
    } fsm_regs_t;

endpackage

// File: rtl/ir_insync.sv
module ir_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol_hi,
    output logic act
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], raw};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{~pol_hi}};
        else        sh_q <= sh_d;
    end

    assign act = pol_hi ? sh_q[STAGES-1] : ~sh_q[STAGES-1];

endmodule

// File: rtl/ir_pulse_timer.sv
module ir_pulse_timer #(
    parameter int CLKS_PER_US = 125,
    parameter int TIMEOUT_US  = 12000,
    parameter int LEN_W       = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    output logic             ev_stb,
    output logic             ev_mark,
    output logic [LEN_W-1:0] ev_len,
    output logic             tmo
);
    localparam int PRE_W = $clog2(CLKS_PER_US + 1);

    typedef struct packed {
        logic             level;
        logic [PRE_W-1:0] pre;
        logic [LEN_W-1:0] len;
        logic             ev_stb;
        logic             ev_mark;
        logic [LEN_W-1:0] ev_len;
        logic             tmo;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.ev_stb = 1'b0;
        r_d.tmo    = 1'b0;
        if (act != r_q.level) begin
            r_d.ev_stb  = 1'b1;
            r_d.ev_mark = r_q.level;
            r_d.ev_len  = r_q.len;
            r_d.level   = act;
            r_d.pre     = '0;
            r_d.len     = '0;
        end else if (r_q.pre == PRE_W'(CLKS_PER_US - 1)) begin
            r_d.pre = '0;
            if (r_q.len != LEN_W'(TIMEOUT_US)) begin
                r_d.len = r_q.len + 1'b1;
            end
            if (r_q.len == LEN_W'(TIMEOUT_US - 1)) begin
                r_d.tmo = 1'b1;
            end
        end else begin
            r_d.pre = r_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ev_stb  = r_q.ev_stb;
    assign ev_mark = r_q.ev_mark;
    assign ev_len  = r_q.ev_len;
    assign tmo     = r_q.tmo;

    // R7: the running length never passes the timeout cap
    a_r7_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.len <= LEN_W'(TIMEOUT_US));

    // R7: the timeout fires once per held level, never on two cycles in a row
    a_r7_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !tmo);

endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
    import ir_pkg::*;
#(
    parameter int LEN_W          = 14,
    parameter int LEAD_MARK_US   = 9000,
    parameter int LEAD_SPACE_US  = 4500,
    parameter int RPT_SPACE_US   = 2250,
    parameter int BIT_MARK_US    = 562,
    parameter int ZERO_SPACE_US  = 562,
    parameter int ONE_SPACE_US   = 1687
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             ev_stb,
    input  logic             ev_mark,
    input  logic [LEN_W-1:0] ev_len,
    input  logic             tmo,
    output logic [15:0]      addr_o,
    output logic [7:0]       cmd_o,
    output logic             frame_valid,
    output logic             frame_err,
    output logic [15:0]      err_raw,
    output logic             repeat_seen
);
    function automatic logic in_win(input logic [LEN_W-1:0] l, input int nom);
        int lo, hi, lv;
        lo = (nom * 3 + 3) / 4;
        hi = (nom * 5) / 4;
        lv = int'(l);
        return (lv >= lo) && (lv <= hi);
    endfunction

    fsm_regs_t r_d, r_q;
    logic      abort;
    logic      bit_one, bit_zero;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.err   = 1'b0;
        r_d.rpt   = 1'b0;
        abort     = 1'b0;
        bit_one   = in_win(ev_len, ONE_SPACE_US);
        bit_zero  = in_win(ev_len, ZERO_SPACE_US);

        if (r_q.state != ST_IDLE && tmo) begin
            abort = 1'b1;
        end else if (ev_stb) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (ev_mark && in_win(ev_len, LEAD_MARK_US)) r_d.state = ST_LSPACE;
                end
                ST_LSPACE: begin
                    if (!ev_mark && in_win(ev_len, LEAD_SPACE_US)) begin
                        r_d.state = ST_BMARK;
                        r_d.cnt   = '0;
                    end else if (!ev_mark && in_win(ev_len, RPT_SPACE_US)) begin
                        r_d.rpt   = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        abort = 1'b1;
                    end
                end
                ST_BMARK: begin
                    if (ev_mark && in_win(ev_len, BIT_MARK_US)) r_d.state = ST_BSPACE;
                    else                                         abort = 1'b1;
                end
                ST_BSPACE: begin
                    if (!ev_mark && (bit_one || bit_zero)) begin
                        r_d.data[r_q.cnt] = bit_one;
                        r_d.cnt           = r_q.cnt + 1'b1;
                        r_d.state         = ST_BMARK;
                        if (r_q.cnt == 5'd15 && !ext_mode &&
                            (r_d.data[7:0] ^ r_d.data[15:8]) != 8'hFF) begin
                            r_d.err     = 1'b1;
                            r_d.err_raw = r_d.data[15:0];
                            r_d.state   = ST_IDLE;
                        end else if (r_q.cnt == 5'd31) begin
                            if ((r_d.data[23:16] ^ r_d.data[31:24]) != 8'hFF) begin
                                r_d.err     = 1'b1;
                                r_d.err_raw = r_d.data[31:16];
                                r_d.state   = ST_IDLE;
                            end else begin
                                r_d.state = ST_STOP;
                            end
                        end
                    end else begin
                        abort = 1'b1;
                    end
                end
                ST_STOP: begin
                    if (ev_mark && in_win(ev_len, BIT_MARK_US)) begin
                        r_d.valid = 1'b1;
                        r_d.addr  = ext_mode ? r_q.data[15:0] : {8'h00, r_q.data[7:0]};
                        r_d.cmd   = r_q.data[23:16];
                        r_d.state = ST_IDLE;
                    end else begin
                        abort = 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end

        if (abort) begin
            r_d.err     = 1'b1;
            r_d.err_raw = '0;
            r_d.state   = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o      = r_q.addr;
    assign cmd_o       = r_q.cmd;
    assign frame_valid = r_q.valid;
    assign frame_err   = r_q.err;
    assign err_raw     = r_q.err_raw;
    assign repeat_seen = r_q.rpt;

    // R9: strobes are exclusive
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_valid, frame_err, repeat_seen}));

    // R5: a reported frame always carries a matching command complement
    a_r5_cmd_complement: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ((cmd_o ^ r_q.data[31:24]) == 8'hFF));

    // R2: standard layout never reports a wide address
    a_r2_std_addr_width: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !$past(ext_mode)) |-> (addr_o[15:8] == 8'h00));

    // R7: a mid-frame timeout ends in idle with an error strobe
    a_r7_timeout_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && r_q.state != ST_IDLE) |=> (r_q.state == ST_IDLE && frame_err));

    // R9: outputs hold between valid frames
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> (!frame_valid || 1'b1) && ($stable(addr_o) || frame_valid));

endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder #(
    parameter int CLKS_PER_US    = 125,
    parameter int LEAD_MARK_US   = 9000,
    parameter int LEAD_SPACE_US  = 4500,
    parameter int RPT_SPACE_US   = 2250,
    parameter int BIT_MARK_US    = 562,
    parameter int ZERO_SPACE_US  = 562,
    parameter int ONE_SPACE_US   = 1687,
    parameter int TIMEOUT_US     = 12000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic        pol_hi,
    input  logic        ext_mode,
    output logic [15:0] addr_o,
    output logic [7:0]  cmd_o,
    output logic        frame_valid,
    output logic        frame_err,
    output logic [15:0] err_raw,
    output logic        repeat_seen
);
    localparam int LEN_W = $clog2(TIMEOUT_US + 1);

    logic             act;
    logic             ev_stb, ev_mark, tmo;
    logic [LEN_W-1:0] ev_len;

    ir_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (ir_in),
        .pol_hi (pol_hi),
        .act    (act)
    );

    ir_pulse_timer #(
        .CLKS_PER_US (CLKS_PER_US),
        .TIMEOUT_US  (TIMEOUT_US),
        .LEN_W       (LEN_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .ev_stb  (ev_stb),
        .ev_mark (ev_mark),
        .ev_len  (ev_len),
        .tmo     (tmo)
    );

    ir_frame_fsm #(
        .LEN_W         (LEN_W),
        .LEAD_MARK_US  (LEAD_MARK_US),
        .LEAD_SPACE_US (LEAD_SPACE_US),
        .RPT_SPACE_US  (RPT_SPACE_US),
        .BIT_MARK_US   (BIT_MARK_US),
        .ZERO_SPACE_US (ZERO_SPACE_US),
        .ONE_SPACE_US  (ONE_SPACE_US)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_mode    (ext_mode),
        .ev_stb      (ev_stb),
        .ev_mark     (ev_mark),
        .ev_len      (ev_len),
        .tmo         (tmo),
        .addr_o      (addr_o),
        .cmd_o       (cmd_o),
        .frame_valid (frame_valid),
        .frame_err   (frame_err),
        .err_raw     (err_raw),
        .repeat_seen (repeat_seen)
    );

endmodule

// File: tb/ir_frame_decoder_tb.sv
module ir_frame_decoder_tb;
    localparam int CPU = 2;
    localparam int LM = 400, LS = 200, RS = 100, BM = 25, ZS = 25, OS = 75, TO = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_in = 1'b1;
    logic pol_hi = 1'b0;
    logic ext_mode = 1'b0;
    logic [15:0] addr_o, err_raw;
    logic [7:0]  cmd_o;
    logic frame_valid, frame_err, repeat_seen;

    int checks = 0, errors = 0;
    int n_valid = 0, n_err = 0, n_rpt = 0, n_multi = 0;
    logic [15:0] last_err_raw = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ir_frame_decoder #(
        .CLKS_PER_US(CPU), .LEAD_MARK_US(LM), .LEAD_SPACE_US(LS), .RPT_SPACE_US(RS),
        .BIT_MARK_US(BM), .ZERO_SPACE_US(ZS), .ONE_SPACE_US(OS), .TIMEOUT_US(TO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .pol_hi(pol_hi), .ext_mode(ext_mode),
        .addr_o(addr_o), .cmd_o(cmd_o), .frame_valid(frame_valid), .frame_err(frame_err),
        .err_raw(err_raw), .repeat_seen(repeat_seen)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) n_valid++;
            if (frame_err) begin n_err++; last_err_raw = err_raw; end
            if (repeat_seen) n_rpt++;
            if (32'(frame_valid) + 32'(frame_err) + 32'(repeat_seen) > 1) n_multi++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_valid = 0; n_err = 0; n_rpt = 0;
    endtask

    task automatic pulse(input logic active, input int us);
        @(negedge clk);
        ir_in = pol_hi ? active : ~active;
        repeat (us * CPU - 1) @(negedge clk);
    endtask

    task automatic go_idle(input int cyc);
        @(negedge clk);
        ir_in = pol_hi ? 1'b0 : 1'b1;
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int nbits,
                             input int mk, input int z, input int o);
        for (int i = 0; i < nbits; i++) begin
            pulse(1'b1, mk);
            pulse(1'b0, w[i] ? o : z);
        end
    endtask

    task automatic send_frame(input logic [31:0] w, input int mk, input int z, input int o);
        pulse(1'b1, LM);
        pulse(1'b0, LS);
        send_bits(w, 32, mk, z, o);
        pulse(1'b1, mk);
        go_idle(40);
    endtask

    function automatic logic [31:0] std_word(input logic [7:0] a, input logic [7:0] c);
        return {~c, c, ~a, a};
    endfunction

    task automatic t_reset();
        check("R10 addr", 32'(addr_o), 0);
        check("R10 cmd", 32'(cmd_o), 0);
        check("R10 strobes", {29'd0, frame_valid, frame_err, repeat_seen}, 0);
        check("R10 err_raw", 32'(err_raw), 0);
    endtask

    task automatic t_std_low();
        clear_counts();
        send_frame(std_word(8'h5A, 8'h3C), BM, ZS, OS);
        check("R2 valid count", n_valid, 1);
        check("R2 addr", 32'(addr_o), 32'h005A);
        check("R2 cmd", 32'(cmd_o), 32'h3C);
        check("R2 no err", n_err, 0);
    endtask

    task automatic t_pol_high();
        @(negedge clk);
        pol_hi = 1'b1; ir_in = 1'b0;
        repeat (20) @(negedge clk);
        clear_counts();
        send_frame(std_word(8'hA1, 8'h07), BM, ZS, OS);
        check("R1 active-high valid", n_valid, 1);
        check("R1 active-high addr", 32'(addr_o), 32'h00A1);
        check("R1 active-high cmd", 32'(cmd_o), 32'h07);
        @(negedge clk);
        pol_hi = 1'b0; ir_in = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 polarity swap quiet", n_err + n_valid, 1);
    endtask

    task automatic t_ext();
        ext_mode = 1'b1;
        clear_counts();
        send_frame({~8'h12, 8'h12, 16'hBEEF}, BM, ZS, OS);
        check("R3 ext valid", n_valid, 1);
        check("R3 ext addr", 32'(addr_o), 32'hBEEF);
        check("R3 ext cmd", 32'(cmd_o), 32'h12);
        check("R3 ext no err", n_err, 0);
        ext_mode = 1'b0;
    endtask

    task automatic t_bad_addr();
        clear_counts();
        send_frame({~8'h44, 8'h44, 8'h9D ^ 8'h01 ^ 8'hFF, 8'h9D} ^ 32'h0, BM, ZS, OS);
        check("R4 err count", n_err, 1);
        check("R4 err_raw", 32'(last_err_raw), {16'd0, 8'h63, 8'h9D});
        check("R4 no valid", n_valid, 0);
        check("R9 addr held", 32'(addr_o), 32'hBEEF);
        check("R9 cmd held", 32'(cmd_o), 32'h12);
    endtask

    task automatic t_bad_cmd();
        clear_counts();
        send_frame({8'hC3, 8'h3D, ~8'h21, 8'h21}, BM, ZS, OS);
        check("R5 err count", n_err, 1);
        check("R5 err_raw", 32'(last_err_raw), 32'hC33D);
        check("R5 no valid", n_valid, 0);
    endtask

    task automatic t_bad_timing();
        clear_counts();
        pulse(1'b1, LM);
        pulse(1'b0, LS);
        send_bits(32'h5, 5, BM, ZS, OS);
        pulse(1'b1, BM);
        pulse(1'b0, 45);
        pulse(1'b1, BM);
        go_idle(40);
        check("R6 bad gap err", n_err, 1);
        check("R6 bad gap raw zero", 32'(last_err_raw), 0);
        check("R6 bad gap no valid", n_valid, 0);
    endtask

    task automatic t_timeout();
        clear_counts();
        pulse(1'b1, LM);
        pulse(1'b0, LS);
        send_bits(32'h3, 3, BM, ZS, OS);
        pulse(1'b1, BM);
        go_idle((TO + 100) * CPU);
        check("R7 timeout err", n_err, 1);
        check("R7 timeout raw zero", 32'(last_err_raw), 0);
    endtask

    task automatic t_repeat();
        clear_counts();
        pulse(1'b1, LM);
        pulse(1'b0, RS);
        pulse(1'b1, BM);
        go_idle(40);
        check("R8 repeat strobe", n_rpt, 1);
        check("R8 no valid or err", n_valid + n_err, 0);
    endtask

    task automatic t_idle_noise();
        clear_counts();
        pulse(1'b1, BM);
        pulse(1'b0, RS);
        pulse(1'b1, 60);
        pulse(1'b0, 30);
        pulse(1'b1, 150);
        go_idle(40);
        check("R11 idle noise quiet", n_valid + n_err + n_rpt, 0);
        check("R11 outputs unchanged", 32'(cmd_o), 32'h12);
    endtask

    task automatic t_tolerance();
        clear_counts();
        send_frame(std_word(8'hE7, 8'h81), 22, 22, 88);
        check("R6 edge timing valid", n_valid, 1);
        check("R6 edge timing addr", 32'(addr_o), 32'h00E7);
        check("R6 edge timing cmd", 32'(cmd_o), 32'h81);
        clear_counts();
        send_frame(std_word(8'h0F, 8'hF0), 29, 29, 62);
        check("R6 edge timing valid b", n_valid, 1);
        check("R6 edge timing cmd b", 32'(cmd_o), 32'hF0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_std_low();
        t_pol_high();
        t_ext();
        t_bad_addr();
        t_bad_cmd();
        t_bad_timing();
        t_timeout();
        t_repeat();
        t_idle_noise();
        t_tolerance();
        check("R9 exclusive strobes", n_multi, 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule